// File: doc/BRIEF.md
# Multi-Pipeline Shared Register File with Bypass

This block holds the architectural registers for a processor core that issues one instruction per cycle into each of several parallel, statically scheduled pipelines. Every pipeline owns two read ports and one write port. All ports operate in the same cycle, so adding a pipeline adds exactly two read ports and one write port.

Each read port returns the freshest copy of the addressed register. A result from an execute stage in the current cycle is bypassed straight to the operand. That result may come from the reading pipeline itself or from any other pipeline. If no execute result matches, a write landing in the same cycle is used. Failing both, the stored value is returned. Writes carry a valid bit and a flush bit, so a squashed instruction never updates state. Two live writes to one register in one cycle break the schedule. The highest-numbered pipeline wins that write, and the block raises a flag.

Top module: `shared_regfile_fwd`

## Requirements
- R1: While reset is asserted, and right after it, every register reads as zero.
- R2: Read port r = 2*p + k (k = 0 or 1) belongs to pipeline p. Its address is `rd_addr[r*AW +: AW]` and its data is `rd_data[r*WIDTH +: WIDTH]`. All 2*NPIPE ports answer in the same cycle.
- R3: A write with `wr_vld[p]`=1 and `wr_flush[p]`=0 is stored at the rising edge. It is returned by later reads that have no newer source.
- R4: When pipeline p's own execute result is valid and its address matches, p's read ports return that result ahead of every other source.
- R5: Otherwise a valid, matching execute result from another pipeline is returned. When several match, the lowest-numbered pipeline is chosen.
- R6: With no matching execute result, a same-cycle enabled write to the addressed register is returned in place of the stored value.
- R7: A write with `wr_flush[p]`=1 neither updates storage nor is forwarded.
- R8: If two or more enabled writes target one register in a cycle, the highest-numbered pipeline's data is stored and forwarded, and `wr_conflict` is 1 in that cycle.
- R9: `wr_conflict` is 0 whenever the enabled writes all target different registers.
- R10: An execute result with `ex_vld[p]`=0 is never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 2*NPIPE*AW | Read addresses, port r in slice r*AW |
| rd_data | output | 2*NPIPE*WIDTH | Read data, port r in slice r*WIDTH |
| ex_vld | input | NPIPE | Execute-stage result valid per pipeline |
| ex_addr | input | NPIPE*AW | Execute-stage destination register per pipeline |
| ex_data | input | NPIPE*WIDTH | Execute-stage result per pipeline |
| wr_vld | input | NPIPE | Write request per pipeline |
| wr_flush | input | NPIPE | Write suppression per pipeline |
| wr_addr | input | NPIPE*AW | Write register per pipeline |
| wr_data | input | NPIPE*WIDTH | Write data per pipeline |
| wr_conflict | output | 1 | Two live writes to one register this cycle |

## Verification
Read data and `wr_conflict` are combinational, so they are due in the same cycle as the stimulus. A write is due one edge later, on reads issued after the rising edge that stores it. The bench drives inputs on the falling edge and compares every port with its reference model 2 ns later, before the next rising edge. It updates the model's storage only after that edge. As a result, same-cycle bypass and next-cycle storage are each checked in the cycle where they must appear.

// File: rtl/shared_regfile_fwd.sv
module shared_regfile_fwd #(
  parameter int NPIPE = 3,
  parameter int NREG  = 8,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(NREG),
  localparam int NRD  = 2 * NPIPE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NRD*AW-1:0]      rd_addr,
  output logic [NRD*WIDTH-1:0]   rd_data,
  input  logic [NPIPE-1:0]       ex_vld,
  input  logic [NPIPE*AW-1:0]    ex_addr,
  input  logic [NPIPE*WIDTH-1:0] ex_data,
  input  logic [NPIPE-1:0]       wr_vld,
  input  logic [NPIPE-1:0]       wr_flush,
  input  logic [NPIPE*AW-1:0]    wr_addr,
  input  logic [NPIPE*WIDTH-1:0] wr_data,
  output logic                   wr_conflict
);

  logic [WIDTH-1:0] regs [NREG];
  logic [NPIPE-1:0] wr_en;
  logic [WIDTH-1:0] rd_q [NRD];

  assign wr_en = wr_vld & ~wr_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NPIPE; i++)
        if (wr_en[i]) regs[wr_addr[i*AW +: AW]] <= wr_data[i*WIDTH +: WIDTH];
    end
  end

  function automatic logic [WIDTH-1:0] pick(int own, logic [AW-1:0] a);
    logic [WIDTH-1:0] v;
    v = regs[a];
    for (int i = 0; i < NPIPE; i++)
      if (wr_en[i] && wr_addr[i*AW +: AW] == a) v = wr_data[i*WIDTH +: WIDTH];
    for (int i = NPIPE - 1; i >= 0; i--)
      if (i != own && ex_vld[i] && ex_addr[i*AW +: AW] == a) v = ex_data[i*WIDTH +: WIDTH];
    if (ex_vld[own] && ex_addr[own*AW +: AW] == a) v = ex_data[own*WIDTH +: WIDTH];
    return v;
  endfunction

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    always_comb rd_q[r] = pick(r / 2, rd_addr[r*AW +: AW]);
    assign rd_data[r*WIDTH +: WIDTH] = rd_q[r];
  end

  always_comb begin
    wr_conflict = 1'b0;
    for (int i = 0; i < NPIPE; i++)
      for (int j = i + 1; j < NPIPE; j++)
        if (wr_en[i] && wr_en[j] && wr_addr[i*AW +: AW] == wr_addr[j*AW +: AW])
          wr_conflict = 1'b1;
  end

endmodule

// File: rtl/shared_regfile_fwd_chk.sv
module shared_regfile_fwd_chk #(
  parameter int NPIPE = 3,
  parameter int NREG  = 8,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(NREG),
  localparam int NRD  = 2 * NPIPE
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NRD*AW-1:0]      rd_addr,
  input logic [NRD*WIDTH-1:0]   rd_data,
  input logic [NPIPE-1:0]       ex_vld,
  input logic [NPIPE*AW-1:0]    ex_addr,
  input logic [NPIPE*WIDTH-1:0] ex_data,
  input logic [NPIPE-1:0]       wr_vld,
  input logic [NPIPE-1:0]       wr_flush,
  input logic [NPIPE*AW-1:0]    wr_addr,
  input logic [NPIPE*WIDTH-1:0] wr_data,
  input logic                   wr_conflict
);

  a_r8_conflict_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    wr_conflict |-> $countones(wr_vld & ~wr_flush) >= 2);

  a_r7_flush_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (&wr_flush) |-> !wr_conflict);

  a_r4_own_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld[0] && rd_addr[AW-1:0] == ex_addr[AW-1:0]) |-> rd_data[WIDTH-1:0] == ex_data[WIDTH-1:0]);

  a_r6_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld == '0 && (wr_vld & ~wr_flush) == 1 && rd_addr[AW-1:0] == wr_addr[AW-1:0])
      |-> rd_data[WIDTH-1:0] == wr_data[WIDTH-1:0]);

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld == '0 && (wr_vld & ~wr_flush) == '0)
      |=> ((ex_vld == '0 && (wr_vld & ~wr_flush) == '0 && $stable(rd_addr)) -> $stable(rd_data)));

endmodule

bind shared_regfile_fwd shared_regfile_fwd_chk #(.NPIPE(NPIPE), .NREG(NREG), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
  .ex_vld(ex_vld), .ex_addr(ex_addr), .ex_data(ex_data),
  .wr_vld(wr_vld), .wr_flush(wr_flush), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_conflict(wr_conflict)
);

// File: tb/test_shared_regfile_fwd.sv
`timescale 1ns/1ps
module test_shared_regfile_fwd;
  localparam int P = 3, NR = 8, AW = 3, W = 32;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [AW-1:0] ra [P][2];
  logic          exv [P], wv [P], wf [P];
  logic [AW-1:0] exa [P], wa [P];
  logic [W-1:0]  exd [P], wd [P];
  logic [W-1:0]  mr [NR];

  logic [2*P*AW-1:0] rd_addr;
  logic [2*P*W-1:0]  rd_data;
  logic [P-1:0]      ex_vld, wr_vld, wr_flush;
  logic [P*AW-1:0]   ex_addr, wr_addr;
  logic [P*W-1:0]    ex_data, wr_data;
  logic              wr_conflict;

  always_comb
    for (int p = 0; p < P; p++) begin
      rd_addr[(2*p)*AW +: AW]   = ra[p][0];
      rd_addr[(2*p+1)*AW +: AW] = ra[p][1];
      ex_vld[p] = exv[p]; ex_addr[p*AW +: AW] = exa[p]; ex_data[p*W +: W] = exd[p];
      wr_vld[p] = wv[p]; wr_flush[p] = wf[p];
      wr_addr[p*AW +: AW] = wa[p]; wr_data[p*W +: W] = wd[p];
    end

  shared_regfile_fwd i_shared_regfile_fwd (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .ex_vld(ex_vld), .ex_addr(ex_addr), .ex_data(ex_data),
    .wr_vld(wr_vld), .wr_flush(wr_flush), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_conflict(wr_conflict));

  int checks = 0, errors = 0;

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference: candidates searched in priority order, first hit wins
  function automatic void ref_read(int p, logic [AW-1:0] a, output logic [W-1:0] v, output string src);
    int order[$];
    order.push_back(p);
    for (int i = 0; i < P; i++) if (i != p) order.push_back(i);
    foreach (order[n]) begin
      int q = order[n];
      if (exv[q] && exa[q] == a) begin v = exd[q]; src = (q == p) ? "R4" : "R5"; return; end
    end
    for (int i = P - 1; i >= 0; i--)
      if (wv[i] && !wf[i] && wa[i] == a) begin v = wd[i]; src = "R6"; return; end
    v = mr[a]; src = "R3";
  endfunction

  task automatic idle();
    for (int p = 0; p < P; p++) begin
      ra[p][0] = 0; ra[p][1] = 0; exv[p] = 0; exa[p] = 0; exd[p] = 0;
      wv[p] = 0; wf[p] = 0; wa[p] = 0; wd[p] = 0;
    end
  endtask

  // Inputs are set after a falling edge; compare 2 ns later, then commit at the rising edge
  task automatic step(string tag);
    int live; bit clash;
    #2;
    for (int p = 0; p < P; p++)
      for (int k = 0; k < 2; k++) begin
        logic [W-1:0] v; string src;
        ref_read(p, ra[p][k], v, src);
        check({src, " ", tag, " R2 port"}, rd_data[(2*p+k)*W +: W], v);
      end
    clash = 0;
    for (int i = 0; i < P; i++)
      for (int j = i + 1; j < P; j++)
        if (wv[i] && !wf[i] && wv[j] && !wf[j] && wa[i] == wa[j]) clash = 1;
    live = 0;
    check(clash ? "R8 conflict" : "R9 conflict", {31'b0, wr_conflict}, {31'b0, clash});
    @(posedge clk);
    for (int i = 0; i < P; i++) if (wv[i] && !wf[i]) mr[wa[i]] = wd[i];
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    for (int r = 0; r < NR; r++) mr[r] = '0;
    repeat (3) @(negedge clk);
    for (int r = 0; r < NR; r += 6) begin
      for (int p = 0; p < P; p++) begin ra[p][0] = AW'(r + 2*p); ra[p][1] = AW'(r + 2*p + 1); end
      #2;
      for (int q = 0; q < 2*P; q++) check("R1 reset", rd_data[q*W +: W], '0);
      @(negedge clk);
    end
    rst_n = 1;
    @(negedge clk);
    idle();

    // R3: independent writes, then read back
    wv[0] = 1; wa[0] = 1; wd[0] = 32'hA1A1_0001;
    wv[1] = 1; wa[1] = 2; wd[1] = 32'hB2B2_0002;
    wv[2] = 1; wa[2] = 3; wd[2] = 32'hC3C3_0003;
    ra[0][0] = 1; ra[1][1] = 2; ra[2][0] = 3;
    step("R3 write");
    idle(); ra[0][0] = 1; ra[0][1] = 2; ra[1][0] = 3; ra[2][1] = 1;
    step("R3 readback");

    // R4 beats R5 and R6
    idle();
    for (int p = 0; p < P; p++) begin exv[p] = 1; exa[p] = 5; exd[p] = 32'h4000_0000 + p; ra[p][0] = 5; ra[p][1] = 5; end
    wv[0] = 1; wa[0] = 5; wd[0] = 32'h6666_6666;
    step("R4 own first");

    // R5 ascending order among other pipes
    idle();
    exv[1] = 1; exa[1] = 6; exd[1] = 32'h5511_0000;
    exv[2] = 1; exa[2] = 6; exd[2] = 32'h5522_0000;
    ra[0][0] = 6; ra[0][1] = 6; ra[2][0] = 6;
    step("R5 cross pipe");

    // R10 invalid execute result ignored
    idle();
    exv[0] = 0; exa[0] = 2; exd[0] = 32'hDEAD_BEEF; ra[0][0] = 2; ra[1][0] = 2;
    step("R10 no bypass");

    // R6 write-through
    idle();
    wv[1] = 1; wa[1] = 4; wd[1] = 32'h0606_0606; ra[0][1] = 4; ra[2][1] = 4;
    step("R6 write through");

    // R7 flushed write
    idle();
    wv[2] = 1; wf[2] = 1; wa[2] = 1; wd[2] = 32'hF1F1_F1F1; ra[0][0] = 1;
    step("R7 flushed");
    idle(); ra[0][0] = 1; ra[1][0] = 1;
    step("R7 not stored");

    // R8 collision: pipe 2 wins, flag raised
    idle();
    wv[0] = 1; wa[0] = 7; wd[0] = 32'h8000_0000;
    wv[2] = 1; wa[2] = 7; wd[2] = 32'h8000_0002;
    ra[1][0] = 7;
    step("R8 collision");
    idle(); ra[1][0] = 7; ra[0][1] = 7;
    step("R8 stored winner");

    // R9 collision masked by flush
    idle();
    wv[0] = 1; wa[0] = 0; wd[0] = 32'h9090_0000;
    wv[1] = 1; wf[1] = 1; wa[1] = 0; wd[1] = 32'h9191_0000;
    ra[2][0] = 0;
    step("R9 flush masks");

    // Mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < P; p++) begin
        ra[p][0] = AW'($urandom_range(0, 7)); ra[p][1] = AW'($urandom_range(0, 7));
        exv[p] = ($urandom_range(0, 2) == 0); exa[p] = AW'($urandom_range(0, 7)); exd[p] = $urandom;
        wv[p] = ($urandom_range(0, 1) == 0); wf[p] = ($urandom_range(0, 3) == 0);
        wa[p] = AW'($urandom_range(0, 7)); wd[p] = $urandom;
      end
      step("random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule